// File: doc/BRIEF.md
# Address-Masked GPIO Port Controller

This block is an 8-pin general purpose I/O port that sits behind a simple 32-bit register bus. The bus has a word address, a write strobe, write data, and read data that follows the address combinationally. A per-pin direction register makes each pin either an output or an input. The data register holds the driven value of each output pin and the sampled level of each input pin.

The whole low quarter of the address space is a data window. Address bits [9:2] of an access act as a pin mask, so software can read or change any chosen group of pins in one access, with no read-modify-write. The port also has these parts:
- interrupt configuration with edge and level detection, and one combined interrupt line;
- an alternate-function select that is guarded by a key-operated lock and a commit mask;
- pad-configuration words that are only stored;
- a read-only block of identification bytes.

Top module: `gpio_port_ctrl`

## Requirements
- R1: A read at a word-aligned offset below 0x400 returns the data register ANDed with the mask taken from address bits [9:2], zero-extended to 32 bits.
- R2: A write into the data window changes only data bits whose mask bit is set and whose direction bit is 1. All other output bits keep their value.
- R3: The direction register is at 0x400, and a 1 makes the pin an output. A pin's output line takes its new data bit on the clock edge after that data bit changes while the pin is an output. The output line of an input pin never changes.
- R4: Each input pin (direction 0) is copied into its data bit on every clock edge. The level on an output pin has no effect on its data bit.
- R5: With sense bit 0, a detected edge on an input pin latches the raw status bit (0x414). Both-edges (0x408) = 1 latches on any edge. Otherwise, polarity bit (0x40c) = 1 latches on a rising edge and 0 latches on a falling edge. Writing 1 to a bit of 0x41c clears the latched bit.
- R6: With sense bit (0x404) = 1, the raw status bit is 1 exactly while the registered input level equals the polarity bit.
- R7: Masked status (0x418) equals raw status AND the mask register (0x410). The irq output is 1 when any masked status bit is 1.
- R8: The port comes out of reset locked, and the lock word (0x520) reads 1 while locked and 0 while unlocked. Writing 0x0ACCE551 to 0x520 unlocks the port, and writing any other value locks it.
- R9: While the port is locked, a write to the alternate-function select (0x420) changes only the bits set in the commit register (0x524). While unlocked, the write changes all bits.
- R10: The eight pad-configuration words at 0x500, 0x504, ... 0x51c each store and read back 8 bits.
- R11: Offsets 0xFD0 to 0xFFC read one identification byte per word: 00,00,00,00,61,00,18,01,0D,F0,05,B1.
- R12: After reset, every register reads zero except the lock word. Unmapped offsets and the write-only clear register read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 12 | Byte offset of the access |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr |
| pin_in | input | 8 | Input level of each pin |
| pin_out | output | 8 | Output line of each pin |
| irq | output | 1 | Combined masked interrupt |

## Verification
The hardest state to reach is a pin that changes direction while edges, clears and masked writes are pending. If a latched interrupt or a stale data bit survives that change, it is easy to miss. The stimulus first sets up mixed directions, then drives levels onto both output and input pins, and only then writes through partial masks. It then returns all pins to inputs at a quiet level and clears the leftover edges before it checks each polarity mode. It also clears one bit while other latched bits stay set, so it can show that the clear acts only on the addressed bit.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
   localparam int unsigned OFF_DIR    = 12'h400;
   localparam int unsigned OFF_SENSE  = 12'h404;
   localparam int unsigned OFF_BOTH   = 12'h408;
   localparam int unsigned OFF_POL    = 12'h40C;
   localparam int unsigned OFF_IMASK  = 12'h410;
   localparam int unsigned OFF_RAW    = 12'h414;
   localparam int unsigned OFF_MSTAT  = 12'h418;
   localparam int unsigned OFF_CLR    = 12'h41C;
   localparam int unsigned OFF_ALT    = 12'h420;
   localparam int unsigned OFF_PAD0   = 12'h500;
   localparam int unsigned OFF_LOCK   = 12'h520;
   localparam int unsigned OFF_COMMIT = 12'h524;
   localparam int unsigned OFF_ID0    = 12'hFD0;
   localparam logic [31:0] UNLOCK_KEY = 32'h0ACC_E551;

   function automatic logic [7:0] ident_byte(input logic [3:0] idx);
      case (idx)
         4'd4:    return 8'h61;
         4'd6:    return 8'h18;
         4'd7:    return 8'h01;
         4'd8:    return 8'h0D;
         4'd9:    return 8'hF0;
         4'd10:   return 8'h05;
         4'd11:   return 8'hB1;
         default: return 8'h00;
      endcase
   endfunction
endpackage

// File: rtl/gpio_pin_data.sv
module gpio_pin_data #(
   parameter int NPINS = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             dir_we,
   input  logic [NPINS-1:0] dir_wdata,
   input  logic             data_we,
   input  logic [NPINS-1:0] data_mask,
   input  logic [NPINS-1:0] data_wdata,
   input  logic [NPINS-1:0] pin_in,
   output logic [NPINS-1:0] dir_q,
   output logic [NPINS-1:0] data_q,
   output logic [NPINS-1:0] pin_out
);
   logic [NPINS-1:0] data_prev, out_q, wmask, data_d, upd;

   assign wmask  = data_we ? (data_mask & dir_q) : '0;
   assign data_d = (((data_q & ~wmask) | (data_wdata & wmask)) & dir_q)
                 | (pin_in & ~dir_q);
   assign upd    = dir_q & (data_q ^ data_prev);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dir_q     <= '0;
         data_q    <= '0;
         data_prev <= '0;
         out_q     <= '0;
      end else begin
         if (dir_we) dir_q <= dir_wdata;
         data_q    <= data_d;
         data_prev <= data_q;
         out_q     <= (out_q & ~upd) | (data_q & upd);
      end
   end

   assign pin_out = out_q;

   p_out_input_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
      ((pin_out ^ $past(pin_out)) & ~$past(dir_q)) == '0);

   p_unmasked_keep_r2: assert property (@(posedge clk) disable iff (!rst_n)
      ((data_q ^ $past(data_q)) & $past(dir_q)
        & ~($past(data_we) ? $past(data_mask) : '0)) == '0);

   p_input_copy_r4: assert property (@(posedge clk) disable iff (!rst_n)
      ((data_q ^ $past(pin_in)) & ~$past(dir_q)) == '0);
endmodule

// File: rtl/gpio_irq_unit.sv
module gpio_irq_unit #(
   parameter int NPINS = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [NPINS-1:0] pin_in,
   input  logic [NPINS-1:0] dir,
   input  logic             sense_we,
   input  logic             both_we,
   input  logic             pol_we,
   input  logic             imask_we,
   input  logic             clr_we,
   input  logic [NPINS-1:0] wdata,
   output logic [NPINS-1:0] sense_q,
   output logic [NPINS-1:0] both_q,
   output logic [NPINS-1:0] pol_q,
   output logic [NPINS-1:0] imask_q,
   output logic [NPINS-1:0] raw,
   output logic [NPINS-1:0] mstat,
   output logic             irq
);
   logic [NPINS-1:0] in_q, lat_q, edge_seen, hit, level, clr_bits;

   assign edge_seen = pin_in ^ in_q;
   assign hit       = edge_seen & (both_q | ~(pin_in ^ pol_q)) & ~sense_q & ~dir;
   assign clr_bits  = clr_we ? wdata : '0;
   assign level     = sense_q & ~(in_q ^ pol_q) & ~dir;
   assign raw       = (lat_q & ~sense_q) | level;
   assign mstat     = raw & imask_q;
   assign irq       = |mstat;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         in_q    <= '0;
         lat_q   <= '0;
         sense_q <= '0;
         both_q  <= '0;
         pol_q   <= '0;
         imask_q <= '0;
      end else begin
         in_q  <= pin_in;
         lat_q <= (lat_q & ~clr_bits) | hit;
         if (sense_we) sense_q <= wdata;
         if (both_we)  both_q  <= wdata;
         if (pol_we)   pol_q   <= wdata;
         if (imask_we) imask_q <= wdata;
      end
   end

   p_latch_needs_edge_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (lat_q & ~$past(lat_q) & ~($past(pin_in) ^ $past(in_q))) == '0);

   p_clear_works_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $past(clr_we) |->
         (lat_q & $past(wdata) & ~($past(pin_in) ^ $past(in_q))) == '0);

   p_irq_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (imask_q == '0) |-> !irq);
endmodule

// File: rtl/gpio_alt_guard.sv
module gpio_alt_guard #(
   parameter int NPINS = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             lock_we,
   input  logic [31:0]      lock_wdata,
   input  logic             commit_we,
   input  logic             alt_we,
   input  logic [NPINS-1:0] wdata,
   output logic             locked,
   output logic [NPINS-1:0] commit_q,
   output logic [NPINS-1:0] alt_q
);
   logic             open_q;
   logic [NPINS-1:0] alt_mask;

   assign locked   = ~open_q;
   assign alt_mask = locked ? commit_q : '1;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         open_q   <= 1'b0;
         commit_q <= '0;
         alt_q    <= '0;
      end else begin
         if (lock_we)   open_q   <= (lock_wdata == gpio_pkg::UNLOCK_KEY);
         if (commit_we) commit_q <= wdata;
         if (alt_we)    alt_q    <= (alt_q & ~alt_mask) | (wdata & alt_mask);
      end
   end

   p_key_decides_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $past(lock_we) |-> (locked == ($past(lock_wdata) != gpio_pkg::UNLOCK_KEY)));

   p_locked_guard_r9: assert property (@(posedge clk) disable iff (!rst_n)
      $past(locked) |-> ((alt_q ^ $past(alt_q)) & ~$past(commit_q)) == '0);
endmodule

// File: rtl/gpio_port_ctrl.sv
module gpio_port_ctrl #(
   parameter int NPINS  = 8,
   parameter int ADDR_W = 12,
   parameter int DATA_W = 32,
   parameter int N_PAD  = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_we,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   input  logic [NPINS-1:0]  pin_in,
   output logic [NPINS-1:0]  pin_out,
   output logic              irq
);
   import gpio_pkg::*;

   localparam int MASK_LSB = 2;
   localparam int MASK_MSB = MASK_LSB + NPINS - 1;

   if (NPINS < 1 || NPINS > 8) begin : g_bad_pins
      $error("NPINS must be 1..8");
   end
   if (ADDR_W != 12) begin : g_bad_addr
      $error("ADDR_W must be 12");
   end
   if (DATA_W != 32) begin : g_bad_data
      $error("DATA_W must be 32");
   end
   if (N_PAD < 1 || N_PAD > 8) begin : g_bad_pad
      $error("N_PAD must be 1..8");
   end

   logic             aligned, in_window, in_ident;
   logic [NPINS-1:0] wd, win_mask;
   logic [NPINS-1:0] dir_q, data_q;
   logic [NPINS-1:0] sense_q, both_q, pol_q, imask_q, raw, mstat;
   logic [NPINS-1:0] commit_q, alt_q;
   logic             locked;
   logic [NPINS-1:0] pad_q [N_PAD];

   assign aligned   = (bus_addr[1:0] == 2'b00);
   assign in_window = aligned && (bus_addr < ADDR_W'(OFF_DIR));
   assign in_ident  = aligned && (bus_addr >= ADDR_W'(OFF_ID0));
   assign wd        = bus_wdata[NPINS-1:0];
   assign win_mask  = bus_addr[MASK_MSB:MASK_LSB];

   function automatic logic hit_wr(input logic [ADDR_W-1:0] a, input logic we,
                                   input int unsigned off);
      return we && (a == ADDR_W'(off));
   endfunction

   gpio_pin_data #(.NPINS(NPINS)) u_data (
      .clk(clk), .rst_n(rst_n),
      .dir_we(hit_wr(bus_addr, bus_we, OFF_DIR)), .dir_wdata(wd),
      .data_we(bus_we && in_window), .data_mask(win_mask), .data_wdata(wd),
      .pin_in(pin_in), .dir_q(dir_q), .data_q(data_q), .pin_out(pin_out)
   );

   gpio_irq_unit #(.NPINS(NPINS)) u_irq (
      .clk(clk), .rst_n(rst_n), .pin_in(pin_in), .dir(dir_q),
      .sense_we(hit_wr(bus_addr, bus_we, OFF_SENSE)),
      .both_we(hit_wr(bus_addr, bus_we, OFF_BOTH)),
      .pol_we(hit_wr(bus_addr, bus_we, OFF_POL)),
      .imask_we(hit_wr(bus_addr, bus_we, OFF_IMASK)),
      .clr_we(hit_wr(bus_addr, bus_we, OFF_CLR)),
      .wdata(wd), .sense_q(sense_q), .both_q(both_q), .pol_q(pol_q),
      .imask_q(imask_q), .raw(raw), .mstat(mstat), .irq(irq)
   );

   gpio_alt_guard #(.NPINS(NPINS)) u_alt (
      .clk(clk), .rst_n(rst_n),
      .lock_we(hit_wr(bus_addr, bus_we, OFF_LOCK)), .lock_wdata(bus_wdata),
      .commit_we(hit_wr(bus_addr, bus_we, OFF_COMMIT)),
      .alt_we(hit_wr(bus_addr, bus_we, OFF_ALT)), .wdata(wd),
      .locked(locked), .commit_q(commit_q), .alt_q(alt_q)
   );

   for (genvar k = 0; k < N_PAD; k++) begin : g_pad
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            pad_q[k] <= '0;
         else if (hit_wr(bus_addr, bus_we, OFF_PAD0 + 4 * k))
            pad_q[k] <= wd;
      end
   end

   always_comb begin
      bus_rdata = '0;
      if (in_window) begin
         bus_rdata = DATA_W'(data_q & win_mask);
      end else if (in_ident) begin
         bus_rdata = DATA_W'(ident_byte(bus_addr[5:2] - 4'd4));
      end else begin
         case (bus_addr)
            ADDR_W'(OFF_DIR):    bus_rdata = DATA_W'(dir_q);
            ADDR_W'(OFF_SENSE):  bus_rdata = DATA_W'(sense_q);
            ADDR_W'(OFF_BOTH):   bus_rdata = DATA_W'(both_q);
            ADDR_W'(OFF_POL):    bus_rdata = DATA_W'(pol_q);
            ADDR_W'(OFF_IMASK):  bus_rdata = DATA_W'(imask_q);
            ADDR_W'(OFF_RAW):    bus_rdata = DATA_W'(raw);
            ADDR_W'(OFF_MSTAT):  bus_rdata = DATA_W'(mstat);
            ADDR_W'(OFF_ALT):    bus_rdata = DATA_W'(alt_q);
            ADDR_W'(OFF_LOCK):   bus_rdata = DATA_W'(locked);
            ADDR_W'(OFF_COMMIT): bus_rdata = DATA_W'(commit_q);
            default:             bus_rdata = '0;
         endcase
         for (int k = 0; k < N_PAD; k++)
            if (bus_addr == ADDR_W'(OFF_PAD0 + 4 * k))
               bus_rdata = DATA_W'(pad_q[k]);
      end
   end

   p_unmapped_zero_r12: assert property (@(posedge clk) disable iff (!rst_n)
      (!aligned) |-> (bus_rdata == '0));
endmodule

// File: tb/test_gpio_port_ctrl.sv
`timescale 1ns/1ps
module test_gpio_port_ctrl;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [11:0] bus_addr = '0;
   logic        bus_we = 1'b0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic [7:0]  pin_in = '0;
   logic [7:0]  pin_out;
   logic        irq;
   int          n_run = 0;
   int          n_fail = 0;
   bit          done = 1'b0;

   always #4 clk = ~clk;

   gpio_port_ctrl i_gpio_port_ctrl (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
      .pin_out(pin_out), .irq(irq)
   );

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [11:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_addr = a; bus_wdata = d; bus_we = 1'b1;
      @(negedge clk);
      bus_we = 1'b0; bus_addr = 12'h7F0;
   endtask

   task automatic rd_check(input logic [11:0] a, input logic [31:0] exp, input string tag);
      @(negedge clk);
      bus_addr = a;
      #1 check(tag, bus_rdata, exp);
   endtask

   task automatic t_reset();
      rd_check(12'h3FC, 0, "R12 data reset");
      rd_check(12'h400, 0, "R12 dir reset");
      rd_check(12'h420, 0, "R12 alt reset");
      rd_check(12'h520, 1, "R8 locked at reset");
      check("R12 pin_out reset", {24'h0, pin_out}, 0);
      check("R12 irq reset", {31'h0, irq}, 0);
   endtask

   task automatic t_ident();
      logic [7:0] ids [12] = '{8'h00, 8'h00, 8'h00, 8'h00, 8'h61, 8'h00,
                               8'h18, 8'h01, 8'h0D, 8'hF0, 8'h05, 8'hB1};
      for (int k = 0; k < 12; k++)
         rd_check(12'hFD0 + 12'(4 * k), {24'h0, ids[k]}, "R11 ident");
      rd_check(12'h600, 0, "R12 unmapped");
      rd_check(12'h41C, 0, "R12 clear reads zero");
   endtask

   task automatic t_data();
      pin_in = 8'hA0;
      wr(12'h400, 32'h0F);
      wr(12'h33 << 2, 32'hFF);
      rd_check(12'h3FC, 32'hA3, "R2 masked write and R4 inputs");
      rd_check(12'h81 << 2, 32'h81, "R1 masked read");
      repeat (2) @(negedge clk);
      check("R3 output follows data", {24'h0, pin_out}, 32'h03);
      wr(12'h3FC, 32'h0C);
      repeat (2) @(negedge clk);
      check("R3 outputs updated", {24'h0, pin_out}, 32'h0C);
      pin_in = 8'h53;
      repeat (2) @(negedge clk);
      rd_check(12'h3FC, 32'h5C, "R4 output pins ignore level");
      check("R3 input pins never driven", {24'h0, pin_out & 8'hF0}, 0);
   endtask

   task automatic t_irq();
      wr(12'h400, 32'h00);
      pin_in = 8'h00;
      repeat (3) @(negedge clk);
      wr(12'h41C, 32'hFF);
      wr(12'h408, 32'h04);
      wr(12'h40C, 32'h01);
      rd_check(12'h414, 0, "R5 raw clean");
      wr(12'h410, 32'hFF);
      pin_in = 8'h07;
      repeat (2) @(negedge clk);
      rd_check(12'h414, 32'h05, "R5 rising and both edges");
      pin_in = 8'h05;
      repeat (2) @(negedge clk);
      rd_check(12'h414, 32'h07, "R5 falling edge");
      check("R7 irq set", {31'h0, irq}, 1);
      wr(12'h410, 32'h02);
      rd_check(12'h418, 32'h02, "R7 masked status");
      wr(12'h41C, 32'h02);
      rd_check(12'h414, 32'h05, "R5 clear one bit");
      rd_check(12'h418, 32'h00, "R7 masked after clear");
      check("R7 irq low", {31'h0, irq}, 0);
      wr(12'h40C, 32'h10);
      wr(12'h404, 32'h10);
      pin_in = 8'h15;
      repeat (2) @(negedge clk);
      rd_check(12'h414, 32'h15, "R6 level high");
      pin_in = 8'h05;
      repeat (2) @(negedge clk);
      rd_check(12'h414, 32'h05, "R6 level low");
   endtask

   task automatic t_lock();
      wr(12'h420, 32'hFF);
      rd_check(12'h420, 0, "R9 locked no commit");
      wr(12'h524, 32'h0C);
      wr(12'h420, 32'hFF);
      rd_check(12'h420, 32'h0C, "R9 commit bits only");
      wr(12'h520, 32'h0ACCE551);
      rd_check(12'h520, 0, "R8 unlocked by key");
      wr(12'h420, 32'h30);
      rd_check(12'h420, 32'h30, "R9 unlocked full write");
      wr(12'h520, 32'h0ACCE550);
      rd_check(12'h520, 1, "R8 relocked");
      wr(12'h420, 32'h03);
      rd_check(12'h420, 32'h30, "R9 relocked guard");
   endtask

   task automatic t_pad();
      for (int k = 0; k < 8; k++)
         wr(12'h500 + 12'(4 * k), 32'(k * 17 + 1));
      for (int k = 0; k < 8; k++)
         rd_check(12'h500 + 12'(4 * k), 32'(k * 17 + 1), "R10 pad storage");
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_ident();
      t_data();
      t_irq();
      t_lock();
      t_pad();
      done = 1'b1;
   end

   initial begin
      fork
         wait (done);
         begin
            #(8 * 100000);
            n_run++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
         end
      join_any
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule